// File: doc/BRIEF.md
# Programmable I2C Clock-Line Timing Generator

This block produces the clock-line waveform for an I2C bus master. The master's byte engine asks it to open a transfer with a START, to run a sequence of bit periods, and to close with a STOP. The generator decides when the clock line is pulled low and when it is released. It tells the byte engine, through one-cycle strobes, when the line has just fallen, when the data line may change, and when the line has risen. It also raises level windows for the START hold and the STOP setup intervals, so that the byte engine knows when the data line must stay steady.

Two pairs of counts are kept: a high/low pair for standard speed and a high/low pair for fast speed. A mode input picks which pair applies. The low phase is counted from the cycle in which the line is pulled low. The high phase starts only after the sampled line reads high, so a slave that holds the clock low stretches the bit. The high phase then runs for the high count plus a fixed overhead. The START hold and STOP setup windows scale with the high count plus a smaller fixed overhead. A data-hold count places the data-change strobe a set number of cycles after each falling edge. When the block is disabled, it releases the line and returns its counters to their start values.

Phases of the state machine: `PH_OFF` (disabled), `PH_IDLE` (bus free), `PH_START_HD` (START hold window), `PH_LOW` (line driven low), `PH_WAIT_HI` (line released, waiting for it to read high), `PH_HIGH` (high phase), `PH_STOP_SU` (STOP setup window). Transitions: OFF→IDLE when enabled; IDLE→START_HD on a start request; START_HD→LOW when the hold window ends; LOW→WAIT_HI when the low count ends; WAIT_HI→HIGH when the line reads high and no STOP is pending, or WAIT_HI→STOP_SU when a STOP is pending; HIGH→LOW when the high count ends; STOP_SU→IDLE when the setup window ends; any phase→OFF when disabled.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and in the cycle after `enable_i` is low, `scl_low_o` and `busy_o` are 0 and no strobe fires. `start_i` has no effect while disabled. A transfer begun after re-enabling has the normal timing.
- R2: When `fast_i`=1 the fast high/low counts apply; when `fast_i`=0 the standard counts apply.
- R3: A one-cycle `start_i` while idle makes `start_win_o`=1 for HCNT+3 cycles with the line released. In the next cycle `scl_low_o` becomes 1. A `start_i` while a transfer is running has no effect on its timing.
- R4: Each low phase holds `scl_low_o`=1 for exactly LCNT+1 cycles. `fall_stb_o` pulses in its first cycle.
- R5: After a low phase the line is released. The high phase (or STOP setup) begins in the cycle after `scl_in_i` is first sampled high, so a low `scl_in_i` stretches the period for as long as it lasts.
- R6: `rise_stb_o` pulses in the first cycle of each high phase. The high phase lasts HCNT+8 cycles, so the next `fall_stb_o` comes HCNT+8 cycles after `rise_stb_o`.
- R7: `sda_stb_o` pulses exactly HOLD cycles after each `fall_stb_o` (HOLD=0 means the same cycle). HOLD must not exceed LCNT.
- R8: A `stop_i` pulse during a transfer takes effect at the following low phase. After that low phase ends and the line reads high, `rise_stb_o` pulses and `stop_win_o`=1 for HCNT+3 cycles, then `busy_o` returns to 0. A `stop_i` while idle is ignored.
- R9: Every strobe is one cycle wide. `rise_stb_o` and `fall_stb_o` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Block enable; low releases the line and clears state |
| fast_i | input | 1 | 1 selects the fast count pair, 0 the standard pair |
| std_hi_i | input | CW | Standard-speed high count |
| std_lo_i | input | CW | Standard-speed low count |
| fast_hi_i | input | CW | Fast-speed high count |
| fast_lo_i | input | CW | Fast-speed low count |
| hold_i | input | CW | Data-hold delay in cycles after a falling edge |
| start_i | input | 1 | One-cycle request to begin a transfer with START |
| stop_i | input | 1 | One-cycle request to end the transfer with STOP |
| scl_in_i | input | 1 | Sampled clock-line level |
| scl_low_o | output | 1 | 1 drives the clock line low, 0 releases it |
| fall_stb_o | output | 1 | Pulse in the first cycle of each low phase |
| sda_stb_o | output | 1 | Pulse when the data line may change |
| rise_stb_o | output | 1 | Pulse in the first cycle after the line is seen high |
| start_win_o | output | 1 | START hold window active |
| stop_win_o | output | 1 | STOP setup window active |
| busy_o | output | 1 | A transfer is in progress |

## Verification
The assertions assume that `start_i` and `stop_i` are single-cycle pulses. They also assume that the count and mode inputs do not change while a transfer runs, that the hold count is no larger than the selected low count, and that `scl_in_i` reads low whenever the block drives the line low. The bench changes counts, mode and hold only while the block is idle or disabled. It models the line as the wired-AND of the block's drive and a bench-controlled stretch, and it keeps every hold value within the low count, including the equal-to-low-count edge.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [2:0] {
        PH_OFF      = 3'd0,
        PH_IDLE     = 3'd1,
        PH_START_HD = 3'd2,
        PH_LOW      = 3'd3,
        PH_WAIT_HI  = 3'd4,
        PH_HIGH     = 3'd5,
        PH_STOP_SU  = 3'd6
    } phase_e;

endpackage

// File: rtl/scl_period_sel.sv
// Chooses the active count pair and turns it into last-cycle limits.
module scl_period_sel #(
    parameter int CW     = 16,
    parameter int HI_OVH = 8,
    parameter int WIN_OVH = 3
) (
    input  logic          fast_i,
    input  logic [CW-1:0] std_hi_i,
    input  logic [CW-1:0] std_lo_i,
    input  logic [CW-1:0] fast_hi_i,
    input  logic [CW-1:0] fast_lo_i,
    output logic [CW:0]   lo_last_o,
    output logic [CW:0]   hi_last_o,
    output logic [CW:0]   win_last_o
);
    localparam int NW = CW + 1;

    logic [CW-1:0] hi_sel;
    logic [CW-1:0] lo_sel;

    always_comb begin
        hi_sel     = fast_i ? fast_hi_i : std_hi_i;
        lo_sel     = fast_i ? fast_lo_i : std_lo_i;
        lo_last_o  = {1'b0, lo_sel};
        hi_last_o  = {1'b0, hi_sel} + NW'(HI_OVH - 1);
        win_last_o = {1'b0, hi_sel} + NW'(WIN_OVH - 1);
    end

endmodule

// File: rtl/scl_phase_cnt.sv
// Cycles-in-phase counter: cleared on every phase change, saturates.
module scl_phase_cnt #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != {W{1'b1}}) begin
            cnt_o <= cnt_o + W'(1);
        end
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CW      = 16,
    parameter int HI_OVH  = 8,
    parameter int WIN_OVH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          fast_i,
    input  logic [CW-1:0] std_hi_i,
    input  logic [CW-1:0] std_lo_i,
    input  logic [CW-1:0] fast_hi_i,
    input  logic [CW-1:0] fast_lo_i,
    input  logic [CW-1:0] hold_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          scl_in_i,
    output logic          scl_low_o,
    output logic          fall_stb_o,
    output logic          sda_stb_o,
    output logic          rise_stb_o,
    output logic          start_win_o,
    output logic          stop_win_o,
    output logic          busy_o
);
    localparam int NW = CW + 1;

    phase_e        ph;
    phase_e        ph_nx;
    logic [NW-1:0] cnt;
    logic [NW-1:0] lo_last;
    logic [NW-1:0] hi_last;
    logic [NW-1:0] win_last;
    logic          stop_pend;
    logic          phase_chg;

    scl_period_sel #(
        .CW     (CW),
        .HI_OVH (HI_OVH),
        .WIN_OVH(WIN_OVH)
    ) u_sel (
        .fast_i    (fast_i),
        .std_hi_i  (std_hi_i),
        .std_lo_i  (std_lo_i),
        .fast_hi_i (fast_hi_i),
        .fast_lo_i (fast_lo_i),
        .lo_last_o (lo_last),
        .hi_last_o (hi_last),
        .win_last_o(win_last)
    );

    assign phase_chg = (ph_nx != ph);

    scl_phase_cnt #(.W(NW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(phase_chg),
        .cnt_o(cnt)
    );

    // next phase
    always_comb begin
        ph_nx = ph;
        unique case (ph)
            PH_OFF:      if (enable_i) ph_nx = PH_IDLE;
            PH_IDLE:     if (start_i) ph_nx = PH_START_HD;
            PH_START_HD: if (cnt == win_last) ph_nx = PH_LOW;
            PH_LOW:      if (cnt == lo_last) ph_nx = PH_WAIT_HI;
            PH_WAIT_HI:  if (scl_in_i) ph_nx = stop_pend ? PH_STOP_SU : PH_HIGH;
            PH_HIGH:     if (cnt == hi_last) ph_nx = PH_LOW;
            PH_STOP_SU:  if (cnt == win_last) ph_nx = PH_IDLE;
            default:     ph_nx = PH_OFF;
        endcase
        if (!enable_i) ph_nx = PH_OFF;
    end

    // phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= PH_OFF;
        end else begin
            ph <= ph_nx;
        end
    end

    // pending STOP request, only taken while a transfer runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_pend <= 1'b0;
        end else if (ph_nx == PH_STOP_SU || ph_nx == PH_IDLE || ph_nx == PH_OFF) begin
            stop_pend <= 1'b0;
        end else if (stop_i) begin
            stop_pend <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        scl_low_o   = (ph == PH_LOW);
        fall_stb_o  = (ph == PH_LOW) && (cnt == '0);
        sda_stb_o   = (ph == PH_LOW) && (cnt == {1'b0, hold_i});
        rise_stb_o  = (ph == PH_HIGH || ph == PH_STOP_SU) && (cnt == '0);
        start_win_o = (ph == PH_START_HD);
        stop_win_o  = (ph == PH_STOP_SU);
        busy_o      = (ph != PH_OFF) && (ph != PH_IDLE);
    end

    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!scl_low_o && !busy_o)); // R1

    AST_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && ph == PH_LOW && cnt < lo_last) |=> scl_low_o); // R4

    AST_LOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low_o) |-> ($past(ph) == PH_START_HD || $past(ph) == PH_HIGH)); // R3

    AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && ph == PH_WAIT_HI && !scl_in_i) |=> (ph == PH_WAIT_HI && !scl_low_o)); // R5

    AST_RISE_SEEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb_o |-> $past(scl_in_i)); // R5

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb_o, fall_stb_o})); // R9

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb_o |=> !fall_stb_o); // R9

endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int SH = 12, SL = 15, FH = 3, FL = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enable_i = 1'b0, fast_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
    logic hold_low = 1'b0;
    logic [CW-1:0] hold_i = '0;
    logic scl_low_o, fall_stb_o, sda_stb_o, rise_stb_o, start_win_o, stop_win_o, busy_o;
    logic scl_line;

    int checks = 0, errors = 0, r9_viol = 0;
    longint cyc = 0;

    typedef struct {int kind; longint at;} exp_t;
    exp_t q[$];

    assign scl_line = ~(scl_low_o | hold_low);

    scl_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .fast_i(fast_i),
        .std_hi_i(CW'(SH)), .std_lo_i(CW'(SL)), .fast_hi_i(CW'(FH)), .fast_lo_i(CW'(FL)),
        .hold_i(hold_i), .start_i(start_i), .stop_i(stop_i), .scl_in_i(scl_line),
        .scl_low_o(scl_low_o), .fall_stb_o(fall_stb_o), .sda_stb_o(sda_stb_o),
        .rise_stb_o(rise_stb_o), .start_win_o(start_win_o), .stop_win_o(stop_win_o),
        .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int k, input longint t);
        exp_t e;
        e.kind = k; e.at = t;
        q.push_back(e);
    endtask

    // monitor: kinds 0 fall (R4), 1 data-change (R7), 2 rise (R6)
    task automatic pop_chk(input int k);
        exp_t e;
        string tags[3];
        tags[0] = "R4 fall strobe"; tags[1] = "R7 sda strobe"; tags[2] = "R6 rise strobe";
        if (q.size() == 0) begin
            chk(1'b0, {tags[k], " unexpected"}, cyc, -1);
        end else begin
            e = q.pop_front();
            chk(e.kind == k, {tags[k], " kind"}, k, e.kind);
            chk(e.at == cyc, {tags[k], " cycle"}, cyc, e.at);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rise_stb_o && fall_stb_o) r9_viol++;
            if (fall_stb_o) pop_chk(0);
            if (sda_stb_o)  pop_chk(1);
            if (rise_stb_o) pop_chk(2);
        end
    end

    task automatic wait_cyc(input longint t);
        while (cyc < t) @(negedge clk);
    endtask

    // driver: n full bits, then final low and STOP; s = stretch cycles of bit 0
    task automatic run_xfer(input bit fast, input int n, input int d, input int s, input bit dup);
        longint c0, f, r, r_stop, rs, rel;
        int h, l;
        h = fast ? FH : SH;
        l = fast ? FL : SL;
        fast_i = fast;
        hold_i = CW'(d);
        c0 = cyc + 1;
        f = c0 + h + 3;
        rel = f + l + 1 + s;
        r_stop = c0;
        rs = 0;
        for (int i = 0; i <= n; i++) begin
            push(0, f);
            push(1, f + d);
            r = f + l + 2 + ((i == 0) ? s : 0);
            push(2, r);
            if (i == n - 1) r_stop = r;
            if (i == n) rs = r;
            f = r + h + 8;
        end
        if (s > 0) hold_low = 1'b1;
        start_i = 1'b1;
        if (n == 0) stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stop_i = 1'b0;
        chk(start_win_o == 1'b1, "R3 start window open", start_win_o, 1);
        chk(scl_low_o == 1'b0, "R3 line released in start window", scl_low_o, 0);
        wait_cyc(c0 + h + 2);
        chk(start_win_o == 1'b1, "R3 start window last cycle", start_win_o, 1);
        wait_cyc(c0 + h + 3);
        chk(start_win_o == 1'b0 && scl_low_o == 1'b1, "R3 low after start window",
            {start_win_o, scl_low_o}, 2'b01);
        if (dup) begin
            wait_cyc(c0 + h + 5);
            start_i = 1'b1;              // R3: must be ignored while busy
            wait_cyc(c0 + h + 6);
            start_i = 1'b0;
        end
        if (s > 0) begin
            wait_cyc(rel - 1);
            chk(busy_o && !scl_low_o, "R5 stretched, line released", {busy_o, scl_low_o}, 2'b10);
            wait_cyc(rel);
            hold_low = 1'b0;
        end
        if (n > 0) begin
            wait_cyc(r_stop);
            stop_i = 1'b1;
            wait_cyc(r_stop + 1);
            stop_i = 1'b0;
        end
        wait_cyc(rs + h + 2);
        chk(stop_win_o == 1'b1, "R8 stop window last cycle", stop_win_o, 1);
        wait_cyc(rs + h + 3);
        chk(stop_win_o == 1'b0 && busy_o == 1'b0, "R8 idle after stop", {stop_win_o, busy_o}, 2'b00);
        chk(q.size() == 0, "R2 all expected edges seen", q.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(scl_low_o == 1'b0 && busy_o == 1'b0, "R1 reset state", {scl_low_o, busy_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: start while disabled is ignored
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && scl_low_o == 1'b0, "R1 start ignored when disabled",
            {busy_o, scl_low_o}, 0);
        enable_i = 1'b1;
        repeat (2) @(negedge clk);

        run_xfer(1'b0, 2, 4, 0, 1'b0);      // R2 standard pair, R4 R6 R7
        run_xfer(1'b1, 3, 0, 0, 1'b1);      // R2 fast pair, hold 0, R3 duplicate start
        run_xfer(1'b1, 1, FL, 0, 1'b0);     // R7 hold equal to low count
        run_xfer(1'b0, 0, 1, 0, 1'b0);      // R8 stop with no full bit
        run_xfer(1'b1, 2, 2, 9, 1'b0);      // R5 stretch on first bit

        // R8: stop in idle ignored -> next transfer runs its full bit count
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        @(negedge clk);
        run_xfer(1'b1, 2, 1, 0, 1'b0);

        // R1: disable in the middle of a low phase
        fast_i = 1'b0;
        hold_i = CW'(2);
        push(0, cyc + 1 + SH + 3);
        push(1, cyc + 1 + SH + 5);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (SH + 5) @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        chk(scl_low_o == 1'b0 && busy_o == 1'b0, "R1 disable releases line",
            {scl_low_o, busy_o}, 0);
        repeat (40) @(negedge clk);
        chk(q.size() == 0, "R1 no strobe while disabled", q.size(), 0);
        q.delete();
        enable_i = 1'b1;
        repeat (2) @(negedge clk);
        run_xfer(1'b0, 1, 3, 0, 1'b0);      // R1 normal timing after re-enable

        chk(r9_viol == 0, "R9 rise and fall never together", r9_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule